// File: doc/BRIEF.md
# GPIO Signal Routing Crossbar

This block connects a row of general-purpose pads to the internal signals of on-chip peripherals through fully programmable multiplexers. Each pad has two selectors. The data selector picks the signal that drives the pad's output level. The enable selector picks the signal that drives the pad's active-low output enable. Either selector can invert its result. Each peripheral input has its own selector, which feeds it a constant 0, a constant 1 or the synchronized level of any pad.

Software programs the routing through a simple 32-bit register port. Writes take effect on the clock edge on which they are presented. Reads are combinational on the address. Pad input levels pass through a two-flop synchronizer before they reach the input selectors, and software can read them as 32-bit banks. The pad outputs and the peripheral inputs are combinational functions of the stored selections and the live source vectors.

Top module: `gpio_xbar`

## Requirements
- R1: After reset every pad data selector holds 0 and every pad enable selector holds 1, both uninverted, and every peripheral input selector holds 0. As a result `pad_o` is all zeros, `pad_oe_n` is all ones and `core_rx` is all zeros.
- R2: The data selector of pad n is at byte offset 0x50 + 8n. Its bits 30..0 hold a source index: 0 gives constant low, 1 gives constant high, and k+2 gives `core_drv[k]`. Bit 31 set inverts the chosen value before it reaches `pad_o[n]`.
- R3: The enable selector of pad n is at byte offset 0x54 + 8n and uses the same index and inversion encoding as R2. It drives `pad_oe_n[n]`, where 0 means the pad drives and 1 means it is tri-stated.
- R4: A pad source index above NUM_DRV+1 routes logic 0 (before inversion). Its register reads back as index NUM_DRV+2 (34 by default) in bits 30..0, with bit 31 as written.
- R5: The selector of peripheral input d is at byte offset 0x250 + 4d. Value 0 feeds 0, value 1 feeds 1, and value k+2 feeds synchronized pad k, so 2..65 cover pads 0..63. Any written 32-bit value above 65 feeds 0 and reads back as 66.
- R6: A change on `pad_i` becomes visible in `core_rx` and in the bank reads after the second rising clock edge, and not after the first.
- R7: A read at byte offset 0x48 + 4b returns the synchronized levels of pads 32b..32b+31, with pad p at bit p mod 32.
- R8: Pad selectors read back bit 31 as the inversion flag and bits 30..0 as the stored index. Input selectors read back their stored value with all other bits 0.
- R9: A read of an unmapped offset, which includes any address whose two low bits are nonzero, returns 0. Writes to unmapped offsets and to the read-only bank offsets change no state.
- R10: A write changes the routed outputs only after the rising edge on which `reg_wr` is high. Before that edge the old selection still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (12) | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| core_drv | input | NUM_DRV (32) | Internal signals available to pad data and enable selectors |
| core_rx | output | NUM_RX (16) | Internal peripheral inputs fed by the input selectors |
| pad_i | input | NUM_PADS (64) | Raw pad input levels |
| pad_o | output | NUM_PADS (64) | Pad output levels |
| pad_oe_n | output | NUM_PADS (64) | Pad output enables, active low |

## Verification
Every data and enable index from constant low, through all internal signals, to past the last legal code is tried with and without inversion. Each routed pad is then checked against the driven signal vector and again against its complement. This separates a true selection from a stuck or constant result and from an off-by-one index. Each peripheral input is swept through every selector value against a fixed, irregular pad pattern. This tells the constants, each pad position and the out-of-range values apart. A pad edge timed against single clock edges shows the synchronizer depth. Writes to misaligned, unmapped and read-only offsets show they leave no trace.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // Register map anchors (byte offsets)
    localparam int unsigned ADDR_BANK_BASE = 32'h048;
    localparam int unsigned ADDR_PAD_BASE  = 32'h050;
    localparam int unsigned PAD_STRIDE     = 8;
    localparam int unsigned EN_OFFSET      = 4;
    localparam int unsigned ADDR_RX_BASE   = 32'h250;
    localparam int unsigned RX_STRIDE      = 4;
    localparam int unsigned BANK_BITS      = 32;

    // Source index encoding shared by all pickers
    localparam int unsigned SRC_LO    = 0;
    localparam int unsigned SRC_HI    = 1;
    localparam int unsigned SRC_FIRST = 2;

    // Saturate a written index: anything past the last legal code
    // collapses to one reserved "no source" code.
    function automatic logic [31:0] sat_src(input logic [31:0] v,
                                            input int unsigned last);
        return (v > last) ? 32'(last + 1) : v;
    endfunction

endpackage

// File: rtl/gpx_src_pick.sv
module gpx_src_pick
    import gpx_pkg::*;
#(
    parameter int unsigned NSRC = 32,
    parameter int unsigned IDXW = 6
) (
    input  logic [IDXW-1:0] idx,
    input  logic            inv,
    input  logic [NSRC-1:0] src,
    output logic            y
);

    logic picked_d;

    always_comb begin
        picked_d = 1'b0;
        if (idx == IDXW'(SRC_HI)) begin
            picked_d = 1'b1;
        end
        for (int j = 0; j < int'(NSRC); j++) begin
            if (idx == IDXW'(j + int'(SRC_FIRST))) begin
                picked_d = src[j];
            end
        end
    end

    assign y = picked_d ^ inv;

endmodule

// File: rtl/gpx_pad_sync.sv
module gpx_pad_sync #(
    parameter int unsigned NUM_PADS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_i,
    output logic [NUM_PADS-1:0] pad_sync
);

    typedef struct packed {
        logic [NUM_PADS-1:0] meta;
        logic [NUM_PADS-1:0] stable;
        logic [1:0]          age;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = pad_i;
        s_d.stable = s_q.meta;
        if (s_q.age != 2'd3) begin
            s_d.age = s_q.age + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pad_sync = s_q.stable;

    // R6: pad level reaches the synchronized view exactly two edges later
    p_two_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.age == 2'd3) |-> (pad_sync == $past(pad_i, 2)));

endmodule

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_PADS = 64,
    parameter int unsigned NUM_DRV  = 32,
    parameter int unsigned NUM_RX   = 16,
    parameter int unsigned AW       = 12,
    parameter int unsigned OW       = 6,
    parameter int unsigned IW       = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [AW-1:0]                 reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_PADS-1:0]           pad_sync,
    output logic [NUM_PADS-1:0][OW:0]     dsel,
    output logic [NUM_PADS-1:0][OW:0]     esel,
    output logic [NUM_RX-1:0][IW-1:0]     isel
);

    localparam int unsigned NUM_BANKS = NUM_PADS / BANK_BITS;
    localparam int unsigned OUT_LAST  = NUM_DRV + SRC_FIRST - 1;
    localparam int unsigned IN_LAST   = NUM_PADS + SRC_FIRST - 1;

    typedef struct packed {
        logic [NUM_PADS-1:0][OW:0]   dsel;
        logic [NUM_PADS-1:0][OW:0]   esel;
        logic [NUM_RX-1:0][IW-1:0]   isel;
    } cfg_t;

    cfg_t        st_d, st_q;
    logic [31:0] rdata_d;
    logic [31:0] cv_d;

    always_comb begin
        st_d    = st_q;
        rdata_d = '0;
        cv_d    = '0;

        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (reg_addr == AW'(int'(ADDR_BANK_BASE) + 4 * b)) begin
                rdata_d = pad_sync[b*BANK_BITS +: BANK_BITS];
            end
        end

        for (int j = 0; j < int'(NUM_PADS); j++) begin
            if (reg_addr == AW'(int'(ADDR_PAD_BASE) + int'(PAD_STRIDE) * j)) begin
                rdata_d     = 32'(st_q.dsel[j][OW-1:0]);
                rdata_d[31] = st_q.dsel[j][OW];
                if (reg_wr) begin
                    cv_d         = sat_src({1'b0, reg_wdata[30:0]}, OUT_LAST);
                    st_d.dsel[j] = {reg_wdata[31], cv_d[OW-1:0]};
                end
            end
            if (reg_addr == AW'(int'(ADDR_PAD_BASE + EN_OFFSET) + int'(PAD_STRIDE) * j)) begin
                rdata_d     = 32'(st_q.esel[j][OW-1:0]);
                rdata_d[31] = st_q.esel[j][OW];
                if (reg_wr) begin
                    cv_d         = sat_src({1'b0, reg_wdata[30:0]}, OUT_LAST);
                    st_d.esel[j] = {reg_wdata[31], cv_d[OW-1:0]};
                end
            end
        end

        for (int d = 0; d < int'(NUM_RX); d++) begin
            if (reg_addr == AW'(int'(ADDR_RX_BASE) + int'(RX_STRIDE) * d)) begin
                rdata_d = 32'(st_q.isel[d]);
                if (reg_wr) begin
                    cv_d         = sat_src(reg_wdata, IN_LAST);
                    st_d.isel[d] = cv_d[IW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.esel <= {NUM_PADS{(OW+1)'(SRC_HI)}};
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = rdata_d;
    assign dsel      = st_q.dsel;
    assign esel      = st_q.esel;
    assign isel      = st_q.isel;

    // R9: offsets below the first bank read as zero
    p_low_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < AW'(ADDR_BANK_BASE)) |-> (reg_rdata == 32'd0));

    // R9: misaligned addresses read as zero
    p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] != 2'b00) |-> (reg_rdata == 32'd0));

    // R10: selections change only through a write strobe
    p_hold_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(st_q));

endmodule

// File: rtl/gpio_xbar.sv
module gpio_xbar
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_PADS = 64,
    parameter int unsigned NUM_DRV  = 32,
    parameter int unsigned NUM_RX   = 16,
    parameter int unsigned AW       = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_DRV-1:0]  core_drv,
    output logic [NUM_RX-1:0]   core_rx,
    input  logic [NUM_PADS-1:0] pad_i,
    output logic [NUM_PADS-1:0] pad_o,
    output logic [NUM_PADS-1:0] pad_oe_n
);

    // Index width holds every legal code plus one reserved "none" code
    localparam int unsigned OW = $clog2(NUM_DRV + SRC_FIRST + 1);
    localparam int unsigned IW = $clog2(NUM_PADS + SRC_FIRST + 1);

    logic [NUM_PADS-1:0]       pad_sync;
    logic [NUM_PADS-1:0][OW:0] dsel;
    logic [NUM_PADS-1:0][OW:0] esel;
    logic [NUM_RX-1:0][IW-1:0] isel;

    gpx_pad_sync #(.NUM_PADS(NUM_PADS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_i    (pad_i),
        .pad_sync (pad_sync)
    );

    gpx_cfg_regs #(
        .NUM_PADS (NUM_PADS),
        .NUM_DRV  (NUM_DRV),
        .NUM_RX   (NUM_RX),
        .AW       (AW),
        .OW       (OW),
        .IW       (IW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_sync  (pad_sync),
        .dsel      (dsel),
        .esel      (esel),
        .isel      (isel)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpx_src_pick #(.NSRC(NUM_DRV), .IDXW(OW)) u_dat (
            .idx (dsel[p][OW-1:0]),
            .inv (dsel[p][OW]),
            .src (core_drv),
            .y   (pad_o[p])
        );
        gpx_src_pick #(.NSRC(NUM_DRV), .IDXW(OW)) u_en (
            .idx (esel[p][OW-1:0]),
            .inv (esel[p][OW]),
            .src (core_drv),
            .y   (pad_oe_n[p])
        );

        // R2: index 0 gives constant low, seen through the inversion bit
        p_dat_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (dsel[p][OW-1:0] == '0) |-> (pad_o[p] == dsel[p][OW]));

        // R3: enable index 1 gives constant high, seen through inversion
        p_en_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (esel[p][OW-1:0] == OW'(SRC_HI)) |-> (pad_oe_n[p] == !esel[p][OW]));

        // R4: out-of-range data index routes 0 before inversion
        p_dat_oob_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dsel[p][OW-1:0] > OW'(NUM_DRV + SRC_FIRST - 1)) |-> (pad_o[p] == dsel[p][OW]));
    end

    for (genvar d = 0; d < NUM_RX; d++) begin : g_rx
        gpx_src_pick #(.NSRC(NUM_PADS), .IDXW(IW)) u_in (
            .idx (isel[d]),
            .inv (1'b0),
            .src (pad_sync),
            .y   (core_rx[d])
        );

        // R5: input constants 0 and 1
        p_rx_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (isel[d] < IW'(SRC_FIRST)) |-> (core_rx[d] == isel[d][0]));
    end

endmodule

// File: tb/gpio_xbar_bench.sv
`timescale 1ns/1ps
module gpio_xbar_bench;

    localparam int NP = 64;
    localparam int ND = 32;
    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [ND-1:0] core_drv = '0;
    logic [NR-1:0] core_rx;
    logic [NP-1:0] pad_i = '0;
    logic [NP-1:0] pad_o;
    logic [NP-1:0] pad_oe_n;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    gpio_xbar u_gpio_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .core_drv  (core_drv),
        .core_rx   (core_rx),
        .pad_i     (pad_i),
        .pad_o     (pad_o),
        .pad_oe_n  (pad_oe_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 12'(a);
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 12'(a);
        #1;
        v = reg_rdata;
    endtask

    function automatic logic exp_out(input int idx, input logic inv, input logic [ND-1:0] drv);
        logic r;
        if (idx == 1) r = 1'b1;
        else if (idx >= 2 && idx < ND + 2) r = drv[idx-2];
        else r = 1'b0;
        return r ^ inv;
    endfunction

    function automatic logic exp_in(input int sel, input logic [NP-1:0] q);
        if (sel == 1) return 1'b1;
        if (sel >= 2 && sel <= NP + 1) return q[sel-2];
        return 1'b0;
    endfunction

    function automatic int clamp_out(input int v);
        return (v > ND + 1) ? ND + 2 : v;
    endfunction

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0]   rv;
        logic [ND-1:0] pat;
        logic [NP-1:0] q;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pad_o", 64'(pad_o), 64'd0);
        chk("R1 pad_oe_n", 64'(pad_oe_n), {64{1'b1}});
        chk("R1 core_rx", 64'(core_rx), 64'd0);
        rd_reg(32'h50, rv); chk("R1 dsel0", 64'(rv), 64'd0);
        rd_reg(32'h54 + 8*63, rv); chk("R1 esel63", 64'(rv), 64'd1);
        rd_reg(32'h250 + 4*15, rv); chk("R1 isel15", 64'(rv), 64'd0);

        // R8 / R4 readback sweep over every pad
        for (int n = 0; n < NP; n++) begin
            int vd = (n * 3) % 50;
            int ve = (n * 7) % 40;
            wr_reg(32'h50 + 8*n, {n[0], 31'(vd)});
            wr_reg(32'h54 + 8*n, {~n[0], 31'(ve)});
            rd_reg(32'h50 + 8*n, rv);
            chk("R8 dsel readback", 64'(rv), 64'({n[0], 31'(clamp_out(vd))}));
            rd_reg(32'h54 + 8*n, rv);
            chk("R8 esel readback", 64'(rv), 64'({~n[0], 31'(clamp_out(ve))}));
        end
        wr_reg(32'h50, 32'h7FFF_FFFF);
        rd_reg(32'h50, rv);
        chk("R4 huge index readback", 64'(rv), 64'(ND + 2));

        // R2 / R4 data routing sweep with pattern and complement
        pat = 32'hA5C3_1E97;
        for (int idx = 0; idx < ND + 5; idx++) begin
            for (int iv = 0; iv < 2; iv++) begin
                int p = (idx * 5 + iv) % NP;
                core_drv = pat;
                wr_reg(32'h50 + 8*p, {iv[0], 31'(idx)});
                #1;
                chk((idx > ND + 1) ? "R4 dat oob" : "R2 dat route", 64'(pad_o[p]),
                    64'(exp_out(idx, iv[0], pat)));
                core_drv = ~pat;
                #1;
                chk("R2 dat route complement", 64'(pad_o[p]),
                    64'(exp_out(idx, iv[0], ~pat)));
            end
        end

        // R3 / R4 enable routing sweep
        for (int idx = 0; idx < ND + 5; idx++) begin
            for (int iv = 0; iv < 2; iv++) begin
                int p = (idx * 3 + iv + 7) % NP;
                core_drv = pat;
                wr_reg(32'h54 + 8*p, {iv[0], 31'(idx)});
                #1;
                chk((idx > ND + 1) ? "R4 en oob" : "R3 en route", 64'(pad_oe_n[p]),
                    64'(exp_out(idx, iv[0], pat)));
                core_drv = ~pat;
                #1;
                chk("R3 en route complement", 64'(pad_oe_n[p]),
                    64'(exp_out(idx, iv[0], ~pat)));
            end
        end

        // R5 input routing sweep
        q = 64'h9E37_79B9_7F4A_7C15;
        @(negedge clk); pad_i = q;
        repeat (3) @(negedge clk);
        for (int d = 0; d < NR; d++) begin
            for (int s = 0; s < NP + 6; s++) begin
                wr_reg(32'h250 + 4*d, 32'(s));
                #1;
                chk("R5 rx route", 64'(core_rx[d]), 64'(exp_in(s, q)));
            end
        end
        wr_reg(32'h250, 32'h8000_0002);
        rd_reg(32'h250, rv);
        chk("R5 big value readback", 64'(rv), 64'(NP + 2));
        chk("R5 big value routes 0", 64'(core_rx[0]), 64'd0);
        wr_reg(32'h250 + 4*3, 32'd40);
        rd_reg(32'h250 + 4*3, rv);
        chk("R8 isel readback", 64'(rv), 64'd40);

        // R6 synchronizer depth
        wr_reg(32'h250, 32'd2);
        @(negedge clk); pad_i = '0;
        repeat (3) @(negedge clk);
        reg_addr = 12'h048;
        pad_i = 64'hFFFF_0000_0F0F_00F1;
        @(posedge clk); #1;
        chk("R6 one edge rx", 64'(core_rx[0]), 64'd0);
        chk("R6 one edge bank", 64'(reg_rdata), 64'd0);
        @(posedge clk); #1;
        chk("R6 two edges rx", 64'(core_rx[0]), 64'd1);
        chk("R6 two edges bank", 64'(reg_rdata), 64'h0F0F_00F1);

        // R7 bank reads
        @(negedge clk); pad_i = q;
        repeat (3) @(negedge clk);
        rd_reg(32'h48, rv); chk("R7 bank0", 64'(rv), 64'(q[31:0]));
        rd_reg(32'h4C, rv); chk("R7 bank1", 64'(rv), 64'(q[63:32]));

        // R9 unmapped reads and ignored writes
        rd_reg(32'h000, rv); chk("R9 rd 0x000", 64'(rv), 64'd0);
        rd_reg(32'h044, rv); chk("R9 rd 0x044", 64'(rv), 64'd0);
        rd_reg(32'h290, rv); chk("R9 rd 0x290", 64'(rv), 64'd0);
        rd_reg(32'h051, rv); chk("R9 rd misaligned", 64'(rv), 64'd0);
        rd_reg(32'hFFC, rv); chk("R9 rd 0xFFC", 64'(rv), 64'd0);
        wr_reg(32'h50, 32'd0);
        wr_reg(32'h250, 32'd1);
        wr_reg(32'h48, 32'h0);
        wr_reg(32'h052, 32'd1);
        wr_reg(32'h252, 32'd0);
        wr_reg(32'h290, 32'd1);
        rd_reg(32'h48, rv); chk("R9 bank write ignored", 64'(rv), 64'(q[31:0]));
        rd_reg(32'h50, rv); chk("R9 misaligned pad write ignored", 64'(rv), 64'd0);
        chk("R9 pad0 output unchanged", 64'(pad_o[0]), 64'd0);
        rd_reg(32'h250, rv); chk("R9 misaligned rx write ignored", 64'(rv), 64'd1);
        chk("R9 rx0 unchanged", 64'(core_rx[0]), 64'd1);

        // R10 write takes effect at the strobed edge
        wr_reg(32'h50 + 8*3, 32'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h050 + 12'd24; reg_wdata = 32'd1;
        #1;
        chk("R10 before edge", 64'(pad_o[3]), 64'd0);
        @(posedge clk); #1;
        reg_wr = 1'b0;
        chk("R10 after edge", 64'(pad_o[3]), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule